// File: doc/BRIEF.md
# ADC Channel-List Scan Sequencer

This block drives a multi-channel analog acquisition. Software fills a sixteen-slot channel list over a 16-bit register bus. Each slot names an input multiplexer channel, a gain code and a polarity. Each time a conversion trigger arrives, the sequencer hands the selected slot to the converter interface and waits for the converter to return a sample. The sample is stored in a small first-in first-out buffer, which software drains over the same bus.

A control register sets a first and a last slot. With scanning enabled, the pointer walks from the first slot to the last, raises an end-of-scan pulse and returns to the first slot. With scanning disabled, the first slot is converted every time, which gives single-channel operation. An optional gate holds off every conversion until an edge arrives on an external start line. Reading a dedicated bus address empties the sample buffer.

Bus map (bus_addr): 0 reads the oldest sample, 1 writes a list slot, 2 writes the control register, 3 writes the mode register, 4 is a read whose only effect is to flush the sample buffer.

Top module: `adc_scan_seq`

## Requirements
- R1: A write to address 1 loads the slot given by wdata bits 11:8. Bit 7 is stored as the unipolar flag, bits 5:4 as the gain code and bits 3:0 as the mux channel. The other bits are ignored.
- R2: When the sequencer is idle and not gated, a cycle with conv_trig high makes conv_start pulse for exactly one cycle on the next cycle. On that same cycle conv_busy rises and conv_mux, conv_gain and conv_unipolar show the slot at the current pointer. conv_busy stays high until a cycle with conv_done high.
- R3: With mode bit 3 set, each finished conversion advances the pointer by one, modulo 16. After the slot at the last index (control bits 11:8) it returns to the first index (control bits 3:0).
- R4: With mode bit 3 clear, every conversion uses the slot at the first index.
- R5: eos pulses for one cycle on the cycle after the conv_done that finishes the slot at the last index, or after every conversion when scanning is off. irq pulses together with eos only when mode bit 1 is set.
- R6: Any write to the control register reloads the pointer with its first index. Writing zero therefore returns the scan to slot 0 and removes the external gate.
- R7: A control write with bit 15 set gates the sequencer, and conv_trig is ignored while the gate is closed. A rising edge on ext_trig observed after that write opens the gate.
- R8: conv_trig is ignored while conv_busy is high. conv_mux, conv_gain and conv_unipolar do not change while a conversion is in progress.
- R9: The sample buffer holds 16 samples in arrival order. A read of address 0 returns the oldest sample on bus_rdata one cycle later and removes it. fifo_empty and fifo_full report the buffer state.
- R10: A sample that arrives while the buffer is full is dropped, and fifo_overflow is set and stays set.
- R11: A read of address 4 empties the buffer and clears fifo_overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a sample read |
| conv_trig | input | 1 | Conversion trigger |
| ext_trig | input | 1 | External start line |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_busy | output | 1 | Conversion in progress |
| conv_mux | output | 4 | Selected mux channel |
| conv_gain | output | 2 | Selected gain code |
| conv_unipolar | output | 1 | Selected polarity, 1 for unipolar |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result |
| eos | output | 1 | End-of-scan pulse |
| irq | output | 1 | End-of-scan interrupt pulse |
| fifo_empty | output | 1 | Sample buffer empty |
| fifo_full | output | 1 | Sample buffer full |
| fifo_overflow | output | 1 | Sticky sample-drop flag |

## Verification
Some properties are checked by assertions on every cycle. These are the shape of the start strobe, the stability of the slot outputs during a conversion, the link between irq, eos and a finished conversion, the flag relationships of the buffer, and the effect of a flush read. Other behaviour can only be shown by the bench's scenarios, where a scoreboard compares every presented slot with a model of the pointer. These are the order of slots across wraps and custom start/end windows, single-channel repetition, the pointer reset by a control write, the external gate, and the content and order of drained samples, including the dropped seventeenth sample.

// File: rtl/adc_scan_pkg.sv
// Package: shared constants and the channel-list entry type.
// Assumes a 16-bit register bus and a 4-bit slot index.
package adc_scan_pkg;
    localparam int BUS_W     = 16;
    localparam int IDX_W     = 4;
    localparam int NUM_SLOTS = 1 << IDX_W;

    localparam logic [2:0] ADDR_SAMPLE = 3'd0;
    localparam logic [2:0] ADDR_LIST   = 3'd1;
    localparam logic [2:0] ADDR_CTRL   = 3'd2;
    localparam logic [2:0] ADDR_MODE   = 3'd3;
    localparam logic [2:0] ADDR_FLUSH  = 3'd4;

    localparam int MODE_SCAN_BIT = 3;
    localparam int MODE_IRQ_BIT  = 1;
    localparam int CTRL_EXT_BIT  = 15;

    typedef struct packed {
        logic       uni;
        logic [1:0] gain;
        logic [3:0] mux;
    } chan_entry_t;
endpackage

// File: rtl/adc_scan_list.sv
// Channel list: sixteen slot registers, each written by slot index embedded
// in the write data. Assumes wr is a one-cycle strobe. Combinational read.
module adc_scan_list
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output chan_entry_t         rd_entry
);
    chan_entry_t slots [NUM_SLOTS];

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            // Load this slot when the embedded index matches it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slots[s] <= '0;
                else if (wr && wdata[11:8] == IDX_W'(s))
                    slots[s] <= '{uni: wdata[7], gain: wdata[5:4], mux: wdata[3:0]};
            end
        end
    endgenerate

    assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan controller: holds mode and control registers, the scan pointer,
// the external start gate and the conversion handshake.
// Assumes conv_done is only meaningful while a conversion is busy.
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                mode_wr,
    input  logic [BUS_W-1:0]    wdata,
    input  logic                conv_trig,
    input  logic                ext_trig,
    input  logic                conv_done,
    input  chan_entry_t         cur_entry,
    output logic [IDX_W-1:0]    ptr,
    output logic                conv_start,
    output logic                conv_busy,
    output chan_entry_t         sel,
    output logic                eos,
    output logic                irq
);
    logic [IDX_W-1:0] first_idx, last_idx;
    logic             scan_en, irq_en, gated, ext_prev;
    logic             ext_rise, launch, finish, at_last;

    assign ext_rise = ext_trig && !ext_prev;
    assign launch   = conv_trig && !conv_busy && !gated;
    assign finish   = conv_busy && conv_done;
    assign at_last  = !scan_en || (ptr == last_idx);

    // Mode register: scan enable and end-of-scan interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_en <= 1'b0;
            irq_en  <= 1'b0;
        end else if (mode_wr) begin
            scan_en <= wdata[MODE_SCAN_BIT];
            irq_en  <= wdata[MODE_IRQ_BIT];
        end
    end

    // Control register and external start gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_idx <= '0;
            last_idx  <= '0;
            gated     <= 1'b0;
            ext_prev  <= 1'b0;
        end else begin
            ext_prev <= ext_trig;
            if (ctrl_wr) begin
                first_idx <= wdata[3:0];
                last_idx  <= wdata[11:8];
                gated     <= wdata[CTRL_EXT_BIT];
            end else if (gated && ext_rise) begin
                gated <= 1'b0;
            end
        end
    end

    // Scan pointer: reload on control write, step or wrap on finish.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ctrl_wr)
            ptr <= wdata[3:0];
        else if (finish)
            ptr <= at_last ? first_idx : ptr + 1'b1;
    end

    // Conversion handshake and latched selection for the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_busy  <= 1'b0;
            conv_start <= 1'b0;
            sel        <= '0;
        end else begin
            conv_start <= launch;
            if (launch) begin
                conv_busy <= 1'b1;
                sel       <= cur_entry;
            end else if (finish) begin
                conv_busy <= 1'b0;
            end
        end
    end

    // End-of-scan and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eos <= 1'b0;
            irq <= 1'b0;
        end else begin
            eos <= finish && at_last;
            irq <= finish && at_last && irq_en;
        end
    end
endmodule

// File: rtl/adc_scan_fifo.sv
// Sample buffer: circular store with occupancy count, sticky overflow and
// a flush that has priority over push and pop. Head is combinational.
module adc_scan_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wptr] <= push_data;
    end

    // Pointers, occupancy and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count    <= count + CW'(do_push) - CW'(do_pop);
            overflow <= overflow || (push && full);
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Top: decodes the register bus, ties the list, controller and sample
// buffer together and registers the read data.
// Assumes single-cycle bus strobes and at most one strobe per cycle.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_trig,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic              conv_busy,
    output logic [3:0]        conv_mux,
    output logic [1:0]        conv_gain,
    output logic              conv_unipolar,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              eos,
    output logic              irq,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_overflow
);
    logic             list_wr, ctrl_wr, mode_wr, smp_rd, flush_rd;
    logic [IDX_W-1:0] ptr;
    chan_entry_t      cur_entry, sel;
    logic [DATA_W-1:0] head;

    assign list_wr  = bus_wr && bus_addr == ADDR_LIST;
    assign ctrl_wr  = bus_wr && bus_addr == ADDR_CTRL;
    assign mode_wr  = bus_wr && bus_addr == ADDR_MODE;
    assign smp_rd   = bus_rd && bus_addr == ADDR_SAMPLE;
    assign flush_rd = bus_rd && bus_addr == ADDR_FLUSH;

    adc_scan_list u_list (
        .clk(clk), .rst_n(rst_n), .wr(list_wr), .wdata(bus_wdata),
        .rd_idx(ptr), .rd_entry(cur_entry)
    );

    adc_scan_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode_wr(mode_wr),
        .wdata(bus_wdata), .conv_trig(conv_trig), .ext_trig(ext_trig),
        .conv_done(conv_done), .cur_entry(cur_entry), .ptr(ptr),
        .conv_start(conv_start), .conv_busy(conv_busy), .sel(sel),
        .eos(eos), .irq(irq)
    );

    adc_scan_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(conv_busy && conv_done),
        .push_data(conv_data), .pop(smp_rd), .flush(flush_rd),
        .head(head), .empty(fifo_empty), .full(fifo_full),
        .overflow(fifo_overflow)
    );

    assign conv_mux      = sel.mux;
    assign conv_gain     = sel.gain;
    assign conv_unipolar = sel.uni;

    // Read data register: oldest sample on a sample read, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (smp_rd)
            bus_rdata <= fifo_empty ? '0 : head;
    end
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Checker: cycle-level properties of the sequencer ports, bound to the top.
module adc_scan_seq_chk
    import adc_scan_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       conv_start,
    input logic       conv_busy,
    input logic       conv_done,
    input logic [3:0] conv_mux,
    input logic [1:0] conv_gain,
    input logic       conv_unipolar,
    input logic       eos,
    input logic       irq,
    input logic       fifo_empty,
    input logic       fifo_full,
    input logic       fifo_overflow
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> conv_busy); // R2
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !conv_start) |-> $stable({conv_mux, conv_gain, conv_unipolar})); // R8
    AST_EOS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> $past(conv_busy && conv_done)); // R5
    AST_IRQ_WITH_EOS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> eos); // R5
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R9
    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_overflow) |-> $past(fifo_full)); // R10
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_FLUSH) |=> (fifo_empty && !fifo_overflow)); // R11
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done),
    .conv_mux(conv_mux), .conv_gain(conv_gain), .conv_unipolar(conv_unipolar),
    .eos(eos), .irq(irq), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_overflow(fifo_overflow)
);

// File: tb/adc_scan_seq_bench.sv
// Scoreboard bench: driver tasks queue expected slot selections and samples,
// a monitor compares presented selections as conversions start.
module adc_scan_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        conv_trig = 1'b0, ext_trig = 1'b0, conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_start, conv_busy, conv_unipolar, eos, irq;
    logic [3:0]  conv_mux;
    logic [1:0]  conv_gain;
    logic        fifo_empty, fifo_full, fifo_overflow;

    always #2 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (.*);

    int checks = 0, fails = 0;
    logic [6:0]  exp_sel[$];
    logic [15:0] exp_smp[$];
    logic [6:0]  m_list[16];
    logic [3:0]  m_first, m_last, m_ptr;
    bit          m_scan, m_irq;
    int          m_cnt = 0;
    logic [15:0] smp_val = 16'hA000;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic put_slot(input int s, input logic uni, input logic [1:0] g, input logic [3:0] m);
        // R1: slot in bits 11:8, unipolar bit 7, gain 5:4, mux 3:0; bit 6 and 15:12 set as junk
        bus_write(3'd1, {4'hF, 4'(s), uni, 1'b1, g, m});
        m_list[s] = {uni, g, m};
    endtask

    task automatic set_ctrl(input logic [15:0] d);
        bus_write(3'd2, d);
        m_first = d[3:0]; m_last = d[11:8]; m_ptr = d[3:0];
    endtask

    task automatic set_mode(input bit scan, input bit irqen);
        bus_write(3'd3, {12'h0, scan, 1'b0, irqen, 1'b0});
        m_scan = scan; m_irq = irqen;
    endtask

    // One full conversion; optionally retrigger while busy (R8).
    task automatic convert(input bit retrig);
        bit last;
        @(negedge clk); conv_trig = 1'b1;
        exp_sel.push_back(m_list[m_ptr]);
        @(negedge clk); conv_trig = 1'b0;
        chk(conv_busy == 1'b1, "R2 busy after trigger", conv_busy, 1);
        if (retrig) conv_trig = 1'b1;
        @(negedge clk); conv_trig = 1'b0;
        @(negedge clk);
        chk(conv_busy == 1'b1, "R2 busy held until done", conv_busy, 1);
        conv_done = 1'b1; conv_data = smp_val;
        if (m_cnt < 16) begin exp_smp.push_back(smp_val); m_cnt++; end
        smp_val++;
        last = !m_scan || (m_ptr == m_last);
        @(negedge clk); conv_done = 1'b0;
        chk(eos == last, "R5 eos", eos, last);
        chk(irq == (last && m_irq), "R5 irq", irq, last && m_irq);
        chk(conv_busy == 1'b0, "R2 idle after done", conv_busy, 0);
        m_ptr = last ? m_first : m_ptr + 4'd1;
    endtask

    task automatic read_sample();
        logic [15:0] e;
        e = exp_smp.pop_front(); m_cnt--;
        @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd0;
        @(negedge clk); bus_rd = 1'b0;
        chk(bus_rdata == e, "R9 sample order", bus_rdata, e);
    endtask

    task automatic flush();
        @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd4;
        @(negedge clk); bus_rd = 1'b0;
        exp_smp.delete(); m_cnt = 0;
        chk(fifo_empty && !fifo_overflow, "R11 flush empties", {fifo_empty, fifo_overflow}, 2'b10);
    endtask

    // Monitor: each start strobe must match the oldest expected selection.
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            if (exp_sel.size() == 0) begin
                chk(1'b0, "R8 unexpected conversion start", 1, 0);
            end else begin
                logic [6:0] e;
                e = exp_sel.pop_front();
                chk({conv_unipolar, conv_gain, conv_mux} == e, "R3 presented slot",
                    {conv_unipolar, conv_gain, conv_mux}, e);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_list[i] = '0;
        m_first = 0; m_last = 0; m_ptr = 0; m_scan = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_empty && !fifo_full && !fifo_overflow && !conv_busy && !eos && !irq,
            "reset state", {fifo_empty, fifo_full, fifo_overflow, conv_busy}, 4'b1000);

        for (int s = 0; s < 8; s++) put_slot(s, s[0], 2'(s), 4'(15 - s));

        // R3 scan 0..3 with wrap, irq enabled
        set_mode(1, 1);
        set_ctrl(16'h0300);
        for (int i = 0; i < 8; i++) convert(0);
        for (int i = 0; i < 8; i++) read_sample();
        chk(fifo_empty == 1'b1, "R9 empty after drain", fifo_empty, 1);

        // R3 window 2..5, irq disabled (R5)
        set_mode(1, 0);
        set_ctrl(16'h0502);
        for (int i = 0; i < 5; i++) convert(0);

        // R4 single channel repeats first slot
        set_mode(0, 1);
        set_ctrl(16'h0306);
        for (int i = 0; i < 3; i++) convert(0);

        // R8 retrigger while busy ignored
        convert(1);
        flush();

        // R6 control write of zero mid-scan returns to slot 0
        set_mode(1, 1);
        set_ctrl(16'h0300);
        convert(0); convert(0);
        set_ctrl(16'h0000);
        convert(0);

        // R7 external gate
        set_ctrl(16'h8300);
        @(negedge clk); conv_trig = 1'b1;
        @(negedge clk); conv_trig = 1'b0;
        chk(!conv_busy && !conv_start, "R7 trigger ignored while gated", conv_busy, 0);
        ext_trig = 1'b1;
        @(negedge clk);
        convert(0); convert(0);
        ext_trig = 1'b0;
        flush();

        // R10 overflow: 17 samples into a 16-deep buffer
        set_mode(0, 0);
        set_ctrl(16'h0001);
        for (int i = 0; i < 16; i++) convert(0);
        chk(fifo_full && !fifo_overflow, "R9 full at 16", {fifo_full, fifo_overflow}, 2'b10);
        convert(0);
        chk(fifo_overflow == 1'b1, "R10 overflow latched", fifo_overflow, 1);
        for (int i = 0; i < 16; i++) read_sample();
        chk(fifo_empty && fifo_overflow, "R10 dropped sample, flag sticky",
            {fifo_empty, fifo_overflow}, 2'b11);
        flush();

        chk(exp_sel.size() == 0, "R2 all starts seen", exp_sel.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule